// File: doc/BRIEF.md
# Multi-Channel PWM Timer with Shadowed Match Values

This block generates six pulse-width-modulated outputs from one shared timebase. A prescale counter divides the clock, and each prescale wrap advances a timer count by one tick. Seven match values are compared against that count. Match value 0 normally ends the period by sending the count back to zero. Match values 1 to 6 place the edges of the outputs. Each output works in one of two modes. In the leading-edge mode the pulse rises at the period boundary. In the two-edge mode the pulse can sit anywhere in the period, because both of its edges come from match values.

Software controls the block through a small synchronous register bus. A write goes into the register selected by the address on the clock edge while write enable is high. Read data always shows the addressed register, with no wait. A new match value is first held in a shadow copy. It reaches the comparator only at the next period boundary caused by match value 0, and only if its latch bit has been armed. So a duty change never produces a truncated pulse or a doubled pulse. Matches can also set interrupt flags, which drive a single interrupt line, and can stop the counter.

Top module: `pwm_match_timer`

## Requirements
- R1: After reset every register reads 0, `pwm_out` is 0 and `irq` is 0.
- R2: The control register sits at address 0. It keeps only bit 0 (run), bit 1 (hold in reset) and bit 3 (output mode), and all its other bits read as 0. While bit 0 is clear and bit 1 is clear, the count at address 2 does not change.
- R3: While control bit 1 is set, the count and the prescale counter are held at 0. Bit 1 takes priority over bit 0.
- R4: With prescale value PR (address 1), the count advances once every PR+1 clock cycles.
- R5: The action register is at address 3. Match k owns bits [3k+2:3k]: bit 3k raises an interrupt, bit 3k+1 resets the count to 0, and bit 3k+2 stops the counter. A tick that finds the count equal to active match value k performs the actions whose bits are set. With the reset action of match 0 set, one period lasts (MR0+1)*(PR+1) clock cycles.
- R6: The mode and enable register is at address 6. Bit n-1 selects two-edge mode for output n, and bit n+7 enables output n. In leading-edge mode, output n (`pwm_out[n-1]`) rises on any counter-reset match and falls on a match with MRn. It is high for min(MRn+1, MR0+1) ticks per period.
- R7: In two-edge mode, output n rises on a match with MR(n-1) and falls on a match with MRn, so it is high for MRn-MR(n-1) ticks when MR(n-1) < MRn. When a set and a clear occur on the same tick, the set wins. The two-edge select bit of output 1 is ignored.
- R8: MRk is written at address 8+k, and that address reads back the active value. A write changes only the shadow copy. At each tick where match 0 resets the count, every shadow whose latch bit (address 5, bit k) is set is copied to the active value, and all latch bits clear. A bus write to the latch register in that same cycle takes priority over the clearing.
- R9: The interrupt flags are at address 4, with bit k for match k. A match whose interrupt action is set sets flag k. Writing 1 to a flag clears it, and writing 0 leaves it unchanged. `irq` is the OR of all flags.
- R10: A match whose stop action is set clears control bit 0, so the count then holds.
- R11: `pwm_out[n-1]` is driven only while control bit 3 and the enable bit of output n are both set. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the addressed register |
| pwm_out | output | 6 | PWM outputs 1 to 6 |
| irq | output | 1 | OR of the match interrupt flags |

## Verification
The hardest situation to reach from the ports is a shadow value waiting to be committed while the period is long. From outside, the bench can see only that the active value has not changed yet. The stimulus first stretches the period with a large match-0 value. It then writes a new match-1 value without arming its latch bit, and reads back the old active value. Only after that does it arm the latch bit, wait out one full long period, and look for the commit and for the latch bit clearing itself. Duty cycles are measured by counting high samples over one whole period. The count does not depend on where the window starts, so the bench needs no knowledge of the internal phase.

// File: rtl/pwm_match_timer.sv
module pwm_match_timer #(
  parameter int CW  = 16,
  parameter int NCH = 6,
  parameter int AW  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  output logic [NCH-1:0] pwm_out,
  output logic          irq
);
  localparam int NM     = NCH + 1;
  localparam int A_CTRL = 0;
  localparam int A_PRE  = 1;
  localparam int A_CNT  = 2;
  localparam int A_ACT  = 3;
  localparam int A_FLG  = 4;
  localparam int A_LAT  = 5;
  localparam int A_MODE = 6;
  localparam int A_MR   = 8;

  logic [2:0]      ctl;
  logic [CW-1:0]   pr, pc, tc;
  logic [3*NM-1:0] act;
  logic [NM-1:0]   flg, lat, hit, int_m, rst_m, stop_m;
  logic [NCH-1:0]  dbl, oe, pq, set_v, clr_v;
  logic [CW-1:0]   mr_a [NM];
  logic [CW-1:0]   mr_s [NM];

  wire run   = ctl[0];
  wire hold  = ctl[1];
  wire mode  = ctl[2];
  wire tick  = run & ~hold & (pc >= pr);
  wire w_lat = wr_en && addr == AW'(A_LAT);
  wire w_flg = wr_en && addr == AW'(A_FLG);

  always_comb
    for (int k = 0; k < NM; k++) begin
      hit[k]    = tick && (tc == mr_a[k]);
      int_m[k]  = act[3*k];
      rst_m[k]  = act[3*k+1];
      stop_m[k] = act[3*k+2];
    end

  wire cnt_rst = |(hit & rst_m);
  wire stop_ev = |(hit & stop_m);
  wire bound   = hit[0] & rst_m[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctl <= '0;
      pr  <= '0;
      act <= '0;
      dbl <= '0;
      oe  <= '0;
    end else begin
      if (wr_en && addr == AW'(A_CTRL)) ctl <= {wdata[3], wdata[1], wdata[0]};
      if (stop_ev) ctl[0] <= 1'b0;
      if (wr_en && addr == AW'(A_PRE)) pr <= wdata[CW-1:0];
      if (wr_en && addr == AW'(A_ACT)) act <= wdata[3*NM-1:0];
      if (wr_en && addr == AW'(A_MODE)) begin
        dbl <= wdata[NCH-1:0];
        oe  <= wdata[8 +: NCH];
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pc <= '0;
      tc <= '0;
    end else if (hold) begin
      pc <= '0;
      tc <= '0;
    end else if (run) begin
      if (tick) begin
        pc <= '0;
        tc <= cnt_rst ? '0 : tc + 1'b1;
      end else
        pc <= pc + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flg <= '0;
      lat <= '0;
    end else begin
      flg <= (flg & ~(w_flg ? wdata[NM-1:0] : '0)) | (hit & int_m);
      if (w_lat)      lat <= wdata[NM-1:0];
      else if (bound) lat <= '0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int k = 0; k < NM; k++) begin
        mr_a[k] <= '0;
        mr_s[k] <= '0;
      end
    end else begin
      for (int k = 0; k < NM; k++) begin
        if (wr_en && addr == AW'(A_MR + k)) mr_s[k] <= wdata[CW-1:0];
        if (bound && lat[k]) mr_a[k] <= mr_s[k];
      end
    end

  always_comb
    for (int n = 0; n < NCH; n++) begin
      set_v[n] = (n > 0 && dbl[n]) ? hit[n] : cnt_rst;
      clr_v[n] = hit[n+1];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pq <= '0;
    else pq <= set_v | (pq & ~clr_v);

  assign pwm_out = pq & oe & {NCH{mode}};
  assign irq     = |flg;

  always_comb begin
    rdata = '0;
    case (addr)
      AW'(A_CTRL): rdata[3:0] = {ctl[2], 1'b0, ctl[1], ctl[0]};
      AW'(A_PRE):  rdata[CW-1:0] = pr;
      AW'(A_CNT):  rdata[CW-1:0] = tc;
      AW'(A_ACT):  rdata[3*NM-1:0] = act;
      AW'(A_FLG):  rdata[NM-1:0] = flg;
      AW'(A_LAT):  rdata[NM-1:0] = lat;
      AW'(A_MODE): begin
        rdata[NCH-1:0]  = dbl;
        rdata[8 +: NCH] = oe;
      end
      default:
        for (int k = 0; k < NM; k++)
          if (addr == AW'(A_MR + k)) rdata[CW-1:0] = mr_a[k];
    endcase
  end

  p_halt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !hold) |=> $stable(tc));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (tc == '0 && pc == '0));

  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !hold) |=> $stable(tc));

  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bound |=> (tc == '0 || $past(hold)));

  p_latclr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bound && !w_lat) |=> (lat == '0));

  p_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(hit & int_m)) |=> irq);

  p_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !ctl[0]);

  for (genvar k = 0; k < NM; k++) begin : g_chk
    p_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bound && lat[k]) |=> (mr_a[k] == $past(mr_s[k])));
  end
endmodule

// File: tb/tb_pwm_match_timer.sv
module tb_pwm_match_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [5:0]  pwm_out;
  logic        irq;

  int tests = 0;
  int fails = 0;

  pwm_match_timer dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out), .irq(irq));

  always #5ns clk = ~clk;

  // pr, mr0, mr1, mr2, two-edge select, expected high ticks of out1, out2
  localparam int NV = 5;
  localparam int VEC [NV][7] = '{
    '{0,  9, 3,  7, 0, 4,  8},
    '{1,  9, 3,  7, 2, 4,  4},
    '{2,  5, 5, 12, 0, 6,  6},
    '{0, 15, 0, 10, 3, 1, 10},
    '{3,  7, 6,  2, 2, 7,  4}
  };

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    addr = 4'(a); wdata = 32'(d); wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(int a, output int v);
    @(negedge clk);
    addr = 4'(a);
    #1ns;
    v = int'(rdata);
  endtask

  task automatic high_count(int ch, int n, output int h);
    h = 0;
    repeat (n) begin
      @(negedge clk);
      if (pwm_out[ch]) h++;
    end
  endtask

  task automatic rise_gap(output int gap);
    int prev;
    int seen;
    gap = -1; seen = 0; prev = int'(pwm_out[0]);
    for (int i = 0; i < 2000 && gap < 0; i++) begin
      @(negedge clk);
      if (seen > 0) seen++;
      if (pwm_out[0] && prev == 0) begin
        if (seen > 0) gap = seen - 1;
        else seen = 1;
      end
      prev = int'(pwm_out[0]);
    end
  endtask

  initial begin
    #1ms;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int v, c1, c2, h, per, g;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 pwm_out", int'(pwm_out), 0);
    chk("R1 irq", int'(irq), 0);
    rd(0, v); chk("R1 ctrl", v, 0);
    rd(2, v); chk("R1 count", v, 0);
    rd(9, v); chk("R1 mr1", v, 0);

    for (int i = 0; i < NV; i++) begin
      wr(0, 2);
      wr(1, VEC[i][0]);
      wr(8, VEC[i][1]);
      wr(9, VEC[i][2]);
      wr(10, VEC[i][3]);
      wr(3, 2);
      wr(6, VEC[i][4] | (32'h3F << 8));
      wr(5, 32'h7F);
      wr(0, 9);
      repeat (400) @(negedge clk);
      per = (VEC[i][1] + 1) * (VEC[i][0] + 1);
      high_count(0, per, h);
      chk($sformatf("R6 vec%0d out1 high", i), h, VEC[i][5] * (VEC[i][0] + 1));
      high_count(1, per, h);
      chk($sformatf("%s vec%0d out2 high", (VEC[i][4] & 2) != 0 ? "R7" : "R6", i),
          h, VEC[i][6] * (VEC[i][0] + 1));
      if (VEC[i][5] != VEC[i][1] + 1) begin
        rise_gap(g);
        chk($sformatf("R5 vec%0d period", i), g, per);
      end
    end

    // R11 per-output enable and mode gating (config of last vector, period 32)
    wr(6, 2 | (32'h3E << 8));
    repeat (40) @(negedge clk);
    high_count(0, 32, h); chk("R11 out1 disabled", h, 0);
    high_count(1, 32, h); chk("R11 out2 still on", h, 16);
    wr(0, 1);
    high_count(1, 64, h); chk("R11 mode off", h, 0);

    // R2 halt and reserved bits; R3 hold
    wr(0, 0);
    rd(2, c1);
    repeat (19) @(negedge clk);
    rd(2, c2); chk("R2 halted count", c2, c1);
    wr(0, -1);
    rd(0, v); chk("R2 reserved bits", v, 32'h0B);
    repeat (5) @(negedge clk);
    rd(2, v); chk("R3 hold count", v, 0);

    // R4 prescale with a long period
    wr(1, 2);
    wr(8, 200);
    wr(5, 1);
    wr(0, 1);
    repeat (100) @(negedge clk);
    rd(2, c1);
    repeat (29) @(negedge clk);
    rd(2, c2); chk("R4 ticks in 30 clocks", c2 - c1, 10);

    // R8 shadowing
    wr(9, 50);
    rd(9, v); chk("R8 mr1 before latch", v, 6);
    rd(5, v); chk("R8 latch idle", v, 0);
    wr(5, 2);
    rd(5, v); chk("R8 latch armed", v, 2);
    repeat (700) @(negedge clk);
    rd(9, v); chk("R8 mr1 committed", v, 50);
    rd(5, v); chk("R8 latch self-clear", v, 0);

    // R9 interrupt flags
    wr(8, 9);
    wr(9, 4);
    wr(5, 3);
    repeat (700) @(negedge clk);
    wr(3, 2 | 8);
    repeat (60) @(negedge clk);
    chk("R9 irq raised", int'(irq), 1);
    rd(4, v); chk("R9 flag bit1", v, 2);
    wr(3, 2);
    wr(4, 1);
    rd(4, v); chk("R9 write0 keeps flag", v, 2);
    wr(4, 2);
    rd(4, v); chk("R9 flag cleared", v, 0);
    repeat (60) @(negedge clk);
    chk("R9 irq low", int'(irq), 0);

    // R10 stop on match 0
    wr(3, 2 | 4);
    repeat (60) @(negedge clk);
    rd(0, v); chk("R10 run bit cleared", v & 1, 0);
    rd(2, c1); chk("R10 count at zero", c1, 0);
    repeat (20) @(negedge clk);
    rd(2, c2); chk("R10 count held", c2, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule